// File: doc/BRIEF.md
# SDRAM Mode Register Programmer

This block writes the mode register of a two-bank SDRAM. At reset the register holds no defined value. The block therefore starts with a flag set that marks initialisation as required. The power-up sequencer pulses `init_go_i` once its own waits, precharges and refreshes are finished. The block then places a Mode Register Set command on the command pins in the next cycle. The register value is packed from the requested CAS latency, burst ordering and burst length.

After initialisation, a controller can ask for a new mode at any time with `prog_req_i`. The device accepts that write only while every bank is idle. A request is therefore held until all bank-idle inputs are high. The command then goes out, followed by one quiet cycle while the device completes the write. `done_o` then pulses for a single clock. In every other cycle the pins carry NOP with a zero address.

Top module: `sdram_mrs_prog`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111) and the address is zero. `busy_o` and `done_o` are 0 and `init_need_o` is 1.
- R2: While `init_need_o` is 1, an `init_go_i` high at a clock edge puts the command on the pins in the cycle after that edge, whatever the bank-idle inputs are. `init_need_o` falls at that same edge and never rises again until reset.
- R3: The Mode Register Set command is {cs_n,ras_n,cas_n,we_n} = 0000. It lasts exactly one cycle.
- R4: During the command cycle the address carries burst length on A2..A0, burst ordering (1 = interleaved) on A3 and CAS latency on A6..A4. All other address bits are 0.
- R5: After initialisation, a `prog_req_i` seen at an edge while all banks are idle and the block is not busy produces the command in the cycle after that edge.
- R6: A run-time request seen while any bank-idle input is 0 stays pending, with `busy_o` high and the pins at NOP. The command follows in the cycle after the first edge at which all banks are idle.
- R7: The cycle after the command is NOP with `busy_o` high. In the cycle after that, `done_o` is 1 for exactly one cycle. `busy_o` is then low unless a further request is pending.
- R8: Outside the command cycle the pins are NOP and the address is zero. `init_go_i` has no effect once initialisation is complete.
- R9: While `init_need_o` is 1, a run-time request produces no command. The initialisation command that follows also serves that request, so no second command is issued.
- R10: The register fields are taken from the inputs at the edge that issues the command. Changes made while a request is pending are used.
- R11: A request that arrives during the command or the quiet cycle is kept. Its command goes out in the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat_i | input | 3 | Requested CAS latency code |
| burst_ilv_i | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| burst_len_i | input | 3 | Requested burst length code |
| prog_req_i | input | 1 | Run-time request to rewrite the mode register |
| init_go_i | input | 1 | Power-up sequencer ready for the mode write |
| bank_idle_i | input | 2 | One idle flag per bank |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address pins A11..A0 |
| busy_o | output | 1 | Request pending or write in progress |
| done_o | output | 1 | One-cycle pulse when the write completes |
| init_need_o | output | 1 | Mode register not yet written since reset |

## Verification
The initialisation write is tried with both banks reported busy, which shows that the power-up path ignores the idle gate. A run-time request with both banks idle is then compared with one made while a single bank is active, which separates an immediate issue from a pending one. Field values are changed while a request waits, which shows whether the fields are sampled at the issue edge or at the request edge. A request made during the quiet cycle, and a request or init strobe made at the wrong time, show whether requests are kept or dropped and whether stray strobes create extra commands.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CMD    = 2'd1,
        ST_SETTLE = 2'd2
    } mrs_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/mrs_word_pack.sv
// Packs the mode fields into the address word driven in the command cycle.
module mrs_word_pack #(
    parameter int ADDR_W = 12,
    parameter int BL_W   = 3,
    parameter int CL_W   = 3,
    parameter int BL_LSB = 0,
    parameter int ILV_AT = 3,
    parameter int CL_LSB = 4
) (
    input  logic [BL_W-1:0]   burst_len_i,
    input  logic              burst_ilv_i,
    input  logic [CL_W-1:0]   cas_lat_i,
    output logic [ADDR_W-1:0] word_o
);
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        if (b >= BL_LSB && b < BL_LSB + BL_W) begin : g_bl
            assign word_o[b] = burst_len_i[b - BL_LSB];
        end else if (b == ILV_AT) begin : g_ilv
            assign word_o[b] = burst_ilv_i;
        end else if (b >= CL_LSB && b < CL_LSB + CL_W) begin : g_cl
            assign word_o[b] = cas_lat_i[b - CL_LSB];
        end else begin : g_zero
            assign word_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/mrs_issue_gate.sv
// Decides whether the command may go out at this edge.
module mrs_issue_gate #(
    parameter int NUM_BANKS = 2
) (
    input  logic                 ready_i,
    input  logic                 init_need_i,
    input  logic                 init_go_i,
    input  logic                 want_i,
    input  logic [NUM_BANKS-1:0] bank_idle_i,
    output logic                 fire_o
);
    logic all_idle;

    assign all_idle = &bank_idle_i;

    always_comb begin
        if (!ready_i) begin
            fire_o = 1'b0;
        end else if (init_need_i) begin
            fire_o = init_go_i;
        end else begin
            fire_o = want_i && all_idle;
        end
    end
endmodule

// File: rtl/sdram_mrs_prog.sv
module sdram_mrs_prog
    import sdram_mrs_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_BANKS = 2,
    parameter int BL_W      = 3,
    parameter int CL_W      = 3,
    parameter int BL_LSB    = 0,
    parameter int ILV_AT    = 3,
    parameter int CL_LSB    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CL_W-1:0]      cas_lat_i,
    input  logic                 burst_ilv_i,
    input  logic [BL_W-1:0]      burst_len_i,
    input  logic                 prog_req_i,
    input  logic                 init_go_i,
    input  logic [NUM_BANKS-1:0] bank_idle_i,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [ADDR_W-1:0]    sd_addr,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 init_need_o
);

    typedef struct packed {
        mrs_state_e          st;
        logic                pend;
        logic                init_need;
        logic                done;
        cmd_pins_t           pins;
        logic [ADDR_W-1:0]   addr;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:        ST_IDLE,
        pend:      1'b0,
        init_need: 1'b1,
        done:      1'b0,
        pins:      PINS_NOP,
        addr:      '0
    };

    regs_t r_q, r_d;
    logic [ADDR_W-1:0] word;
    logic fire;

    mrs_word_pack #(
        .ADDR_W (ADDR_W),
        .BL_W   (BL_W),
        .CL_W   (CL_W),
        .BL_LSB (BL_LSB),
        .ILV_AT (ILV_AT),
        .CL_LSB (CL_LSB)
    ) u_pack (
        .burst_len_i (burst_len_i),
        .burst_ilv_i (burst_ilv_i),
        .cas_lat_i   (cas_lat_i),
        .word_o      (word)
    );

    mrs_issue_gate #(
        .NUM_BANKS (NUM_BANKS)
    ) u_gate (
        .ready_i     (r_q.st == ST_IDLE),
        .init_need_i (r_q.init_need),
        .init_go_i   (init_go_i),
        .want_i      (r_q.pend || prog_req_i),
        .bank_idle_i (bank_idle_i),
        .fire_o      (fire)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.pins = PINS_NOP;
        r_d.addr = '0;
        if (prog_req_i) begin
            r_d.pend = 1'b1;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (fire) begin
                    r_d.st        = ST_CMD;
                    r_d.pins      = PINS_MRS;
                    r_d.addr      = word;
                    r_d.pend      = 1'b0;
                    r_d.init_need = 1'b0;
                end
            end
            ST_CMD: begin
                r_d.st = ST_SETTLE;
            end
            ST_SETTLE: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign sd_cs_n     = r_q.pins.cs_n;
    assign sd_ras_n    = r_q.pins.ras_n;
    assign sd_cas_n    = r_q.pins.cas_n;
    assign sd_we_n     = r_q.pins.we_n;
    assign sd_addr     = r_q.addr;
    assign busy_o      = r_q.pend || (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign init_need_o = r_q.init_need;

endmodule

// File: rtl/sdram_mrs_prog_chk.sv
module sdram_mrs_prog_chk #(
    parameter int ADDR_W    = 12,
    parameter int NUM_BANKS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] bank_idle_i,
    input logic                 sd_cs_n,
    input logic                 sd_ras_n,
    input logic                 sd_cas_n,
    input logic                 sd_we_n,
    input logic [ADDR_W-1:0]    sd_addr,
    input logic                 busy_o,
    input logic                 done_o,
    input logic                 init_need_o
);
    logic is_mrs, is_nop;

    assign is_mrs = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000);
    assign is_nop = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111);

    assert_mrs_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |=> is_nop);

    assert_settle_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |=> (busy_o && !done_o));

    assert_done_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> ##2 done_o);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idle_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mrs && !$past(init_need_o)) |-> $past(&bank_idle_i));

    assert_init_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_need_o) |-> is_mrs);

    assert_init_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_need_o |=> !init_need_o);

    assert_quiet_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mrs |-> (is_nop && sd_addr == '0));

endmodule

bind sdram_mrs_prog sdram_mrs_prog_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_idle_i (bank_idle_i),
    .sd_cs_n     (sd_cs_n),
    .sd_ras_n    (sd_ras_n),
    .sd_cas_n    (sd_cas_n),
    .sd_we_n     (sd_we_n),
    .sd_addr     (sd_addr),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .init_need_o (init_need_o)
);

// File: tb/sim_sdram_mrs_prog.sv
module sim_sdram_mrs_prog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cas_lat = '0;
    logic        burst_ilv = 1'b0;
    logic [2:0]  burst_len = '0;
    logic        prog_req = 1'b0;
    logic        init_go = 1'b0;
    logic [1:0]  bank_idle = 2'b11;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [11:0] addr;
    logic        busy, done, init_need;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sdram_mrs_prog u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cas_lat_i   (cas_lat),
        .burst_ilv_i (burst_ilv),
        .burst_len_i (burst_len),
        .prog_req_i  (prog_req),
        .init_go_i   (init_go),
        .bank_idle_i (bank_idle),
        .sd_cs_n     (cs_n),
        .sd_ras_n    (ras_n),
        .sd_cas_n    (cas_n),
        .sd_we_n     (we_n),
        .sd_addr     (addr),
        .busy_o      (busy),
        .done_o      (done),
        .init_need_o (init_need)
    );

    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_MRS = 4'b0000;

    function automatic logic [3:0] pins();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    function automatic logic [11:0] exp_word(input logic [2:0] cl, input logic ilv, input logic [2:0] bl);
        return {5'b0, cl, ilv, bl};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Command already on the pins: check the quiet cycle, done pulse and return to idle.
    task automatic tail(input string tag, input logic busy_after);
        step();
        chk({tag, " R7 quiet pins"}, pins(), P_NOP);
        chk({tag, " R7 busy in quiet"}, busy, 1'b1);
        chk({tag, " R7 no early done"}, done, 1'b0);
        step();
        chk({tag, " R7 done pulse"}, done, 1'b1);
        chk({tag, " R7 busy after"}, busy, busy_after);
        chk({tag, " R8 pins at done"}, pins(), P_NOP);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        chk("R1 pins in reset", pins(), P_NOP);
        rst_n = 1'b1;
        step();
        chk("R1 pins", pins(), P_NOP);
        chk("R1 addr", addr, 12'h0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 init_need", init_need, 1'b1);
    endtask

    task automatic t_init_blocks_runtime();
        bank_idle = 2'b11;
        cas_lat = 3'd2; burst_ilv = 1'b0; burst_len = 3'd3;
        prog_req = 1'b1;
        step();
        prog_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R9 no command before init", pins(), P_NOP);
            chk("R9 request held busy", busy, 1'b1);
            chk("R9 init still needed", init_need, 1'b1);
            step();
        end
    endtask

    task automatic t_init();
        bank_idle = 2'b00;
        init_go = 1'b1;
        step();
        init_go = 1'b0;
        chk("R2 init command with banks busy", pins(), P_MRS);
        chk("R3 command encoding", pins(), P_MRS);
        chk("R4 packed word init", addr, exp_word(3'd2, 1'b0, 3'd3));
        chk("R2 init flag cleared", init_need, 1'b0);
        tail("init", 1'b0);
        bank_idle = 2'b11;
        step();
        chk("R7 done one cycle", done, 1'b0);
        chk("R9 no second command", pins(), P_NOP);
        step();
        chk("R9 still quiet", pins(), P_NOP);
        chk("R2 flag stays low", init_need, 1'b0);
    endtask

    task automatic t_runtime();
        bank_idle = 2'b11;
        cas_lat = 3'd3; burst_ilv = 1'b1; burst_len = 3'd7;
        prog_req = 1'b1;
        step();
        prog_req = 1'b0;
        chk("R5 immediate command", pins(), P_MRS);
        chk("R4 packed word run", addr, exp_word(3'd3, 1'b1, 3'd7));
        tail("run", 1'b0);
        step();
        chk("R3 single command", pins(), P_NOP);
    endtask

    task automatic t_pending();
        bank_idle = 2'b10;
        cas_lat = 3'd1; burst_ilv = 1'b0; burst_len = 3'd0;
        prog_req = 1'b1;
        step();
        prog_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R6 held while bank active", pins(), P_NOP);
            chk("R6 busy while pending", busy, 1'b1);
            step();
        end
        bank_idle = 2'b01;
        step();
        chk("R6 held other bank active", pins(), P_NOP);
        cas_lat = 3'd2; burst_ilv = 1'b1; burst_len = 3'd1;
        bank_idle = 2'b11;
        step();
        chk("R6 issued once idle", pins(), P_MRS);
        chk("R10 late fields used", addr, exp_word(3'd2, 1'b1, 3'd1));
        tail("pend", 1'b0);
    endtask

    task automatic t_back_to_back();
        bank_idle = 2'b11;
        cas_lat = 3'd2; burst_ilv = 1'b0; burst_len = 3'd2;
        prog_req = 1'b1;
        step();
        prog_req = 1'b1;
        chk("R5 first command", pins(), P_MRS);
        step();
        prog_req = 1'b0;
        cas_lat = 3'd3; burst_len = 3'd1;
        chk("R11 quiet cycle", pins(), P_NOP);
        step();
        chk("R11 done", done, 1'b1);
        chk("R11 busy with pending", busy, 1'b1);
        step();
        chk("R11 second command", pins(), P_MRS);
        chk("R11 second word", addr, exp_word(3'd3, 1'b0, 3'd1));
        tail("b2b", 1'b0);
    endtask

    task automatic t_init_go_ignored();
        bank_idle = 2'b11;
        init_go = 1'b1;
        step();
        init_go = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R8 init strobe ignored", pins(), P_NOP);
            chk("R8 addr zero", addr, 12'h0);
            chk("R8 not busy", busy, 1'b0);
            step();
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_init_blocks_runtime();
        t_init();
        t_runtime();
        t_pending();
        t_back_to_back();
        t_init_go_ignored();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule